// File: doc/BRIEF.md
# Distributed Multiprocessor Bus Arbiter Node

This block is the arbitration logic held by each processor node that shares one external bus with up to five other processor nodes and a host. Every node sees the full set of processor request lines, the host request, the shared lock line and the priority-mode setting, and is told its own three-bit ID. Every copy holds the same small state and applies the same next-state rule to the same inputs, so all copies name the same owner in the same cycle. No central arbiter is needed: each node reads its own `bus_master` flag to learn whether it may drive the bus.

A processor that wins the bus keeps it for as long as its request bit stays high. When it drops the request, the next owner appears on the outputs after one clock edge. The host is served ahead of every processor at that point. The lock line freezes ownership so that a read-modify-write sequence cannot be split. With no requests at all, the last owner keeps the bus parked. The next owner among processors is picked by one of two rules. Under fixed priority the lowest ID wins. Under rotating priority the search starts just after the last processor master.

Top module: `busarb_node`

## Requirements
- R1: After a synchronous reset, `owner_id` is 1 and `host_grant` is 0, so only the node whose ID is 1 sees `bus_master` high.
- R2: Ownership changes one clock edge after the inputs that cause the change are sampled. No idle cycle lies between the old master and the new one.
- R3: With `cfg_rotate` = 0 (fixed mode), the lowest requesting ID becomes the new processor owner when the bus is released.
- R4: With `cfg_rotate` = 1 (rotating mode), the search runs from the ID one above the last processor owner, upward, and wraps from the highest ID back to ID 1. The first requester found wins.
- R5: A processor owner whose own request bit is high keeps the bus, whatever the other requests are.
- R6: When `host_req` is high and the current processor owner's request bit is low, the host takes the bus. `host_grant` then goes to 1, `owner_id` reads 0, and no node has `bus_master` set.
- R7: The host keeps the bus while `host_req` stays high. When `host_req` falls, the processors are arbitrated under the current mode, counting from the last processor owner. If no processor requests, ownership returns to that last processor owner.
- R8: While `lock` is high, `owner_id` and `host_grant` do not change, and all requests, including the host request, have no effect.
- R9: With no processor request and no host request, `owner_id` keeps its value (parked ownership).
- R10: `bus_master` is high exactly when the host does not own the bus and `owner_id` equals `my_id`. At most one node with a distinct ID has it set, and it is never high together with `host_grant`.
- R11: Bit k of `req_lines` is the request of the processor whose ID is k+1. `owner_id` never exceeds the node count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_rotate | input | 1 | Priority mode: 0 fixed, 1 rotating |
| my_id | input | 3 | This node's own ID (1..6) |
| req_lines | input | 6 | Processor requests, bit k for ID k+1 |
| host_req | input | 1 | Host bus request |
| lock | input | 1 | Shared bus lock; freezes ownership |
| bus_master | output | 1 | High when this node owns the bus |
| host_grant | output | 1 | High when the host owns the bus |
| owner_id | output | 3 | Current processor owner ID, 0 while the host owns the bus |

## Verification
Directed phases come first. Several requesters release the bus under fixed priority, which separates lowest-ID selection from any rotation. The same release pattern is then run under rotating priority, including a wrap past ID 6, which shows that the search starts after the last master rather than at ID 1. The host is made to request while a processor still holds the bus, then after the processor releases, then while the lock is high. These cases separate waiting for release from preempting the owner, and show that the lock also holds off the host. A long pseudo-random phase with rare locks follows. In every cycle, the outputs of two nodes with different IDs are compared against a behavioural model of owner, host and last-master state.

// File: rtl/busarb_pkg.sv
package busarb_pkg;

    localparam int ID_W      = 3;
    localparam int MAX_NODES = (1 << ID_W) - 2;

    typedef logic [ID_W-1:0] node_id_t;

    typedef enum logic {
        PRIO_FIXED  = 1'b0,
        PRIO_ROTATE = 1'b1
    } prio_e;

    // Ownership state, identical in every node.
    typedef struct packed {
        logic     host_owns;   // host currently owns the bus
        node_id_t owner;       // current or most recent processor owner
    } own_state_t;

    typedef struct packed {
        logic     valid;
        node_id_t id;
    } pick_t;

    localparam node_id_t RESET_OWNER = node_id_t'(1);

    function automatic node_id_t idx_to_id(input int idx);
        return node_id_t'(idx + 1);
    endfunction

endpackage

// File: rtl/busarb_pick_fixed.sv
module busarb_pick_fixed
    import busarb_pkg::*;
#(
    parameter int NODES = 6
) (
    input  logic [NODES-1:0] req,
    output pick_t            pick
);

    // Scan from the top down so that the lowest requesting index is the
    // last one written, which gives it the win.
    always_comb begin
        pick = '0;
        for (int i = NODES - 1; i >= 0; i--) begin
            if (req[i]) begin
                pick.valid = 1'b1;
                pick.id    = idx_to_id(i);
            end
        end
    end

endmodule

// File: rtl/busarb_pick_rotate.sv
module busarb_pick_rotate
    import busarb_pkg::*;
#(
    parameter int NODES = 6
) (
    input  logic [NODES-1:0] req,
    input  node_id_t         last_id,
    output pick_t            pick
);

    // The index of the node after last_id equals last_id itself, because
    // IDs are index + 1. Wrap that start point into range first.
    always_comb begin
        int start;
        int idx;
        pick  = '0;
        start = int'(last_id);
        if (start >= NODES) begin
            start = 0;
        end
        // Descending distance: the nearest requester is the last one written.
        for (int k = NODES - 1; k >= 0; k--) begin
            idx = start + k;
            if (idx >= NODES) begin
                idx = idx - NODES;
            end
            if (req[idx]) begin
                pick.valid = 1'b1;
                pick.id    = idx_to_id(idx);
            end
        end
    end

endmodule

// File: rtl/busarb_next.sv
module busarb_next
    import busarb_pkg::*;
#(
    parameter int NODES = 6
) (
    input  own_state_t       cur,
    input  logic [NODES-1:0] req,
    input  logic             host_req,
    input  logic             lock,
    input  prio_e            mode,
    input  pick_t            fix_pick,
    input  pick_t            rot_pick,
    output own_state_t       nxt
);

    logic  owner_req;
    pick_t win;

    // Request bit of the current processor owner.
    always_comb begin
        owner_req = 1'b0;
        for (int i = 0; i < NODES; i++) begin
            if (cur.owner == idx_to_id(i)) begin
                owner_req = req[i];
            end
        end
    end

    always_comb begin
        win = (mode == PRIO_ROTATE) ? rot_pick : fix_pick;
    end

    always_comb begin
        nxt = cur;
        if (!lock) begin
            if (cur.host_owns) begin
                if (!host_req) begin
                    nxt.host_owns = 1'b0;
                    if (win.valid) begin
                        nxt.owner = win.id;
                    end
                end
            end else if (!owner_req) begin
                if (host_req) begin
                    nxt.host_owns = 1'b1;
                end else if (win.valid) begin
                    nxt.owner = win.id;
                end
            end
        end
    end

endmodule

// File: rtl/busarb_node.sv
module busarb_node
    import busarb_pkg::*;
#(
    parameter int NODES          = 6,
    parameter bit ROTATE_SUPPORT = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_rotate,
    input  logic [ID_W-1:0]  my_id,
    input  logic [NODES-1:0] req_lines,
    input  logic             host_req,
    input  logic             lock,
    output logic             bus_master,
    output logic             host_grant,
    output logic [ID_W-1:0]  owner_id
);

    own_state_t state_q;
    own_state_t state_d;
    pick_t      fix_pick;
    pick_t      rot_pick;
    prio_e      mode;

    assign mode = ROTATE_SUPPORT ? prio_e'(cfg_rotate) : PRIO_FIXED;

    busarb_pick_fixed #(.NODES(NODES)) u_fixed (
        .req  (req_lines),
        .pick (fix_pick)
    );

    generate
        if (ROTATE_SUPPORT) begin : g_rot
            busarb_pick_rotate #(.NODES(NODES)) u_rot (
                .req     (req_lines),
                .last_id (state_q.owner),
                .pick    (rot_pick)
            );
        end else begin : g_norot
            assign rot_pick = fix_pick;
        end
    endgenerate

    busarb_next #(.NODES(NODES)) u_next (
        .cur      (state_q),
        .req      (req_lines),
        .host_req (host_req),
        .lock     (lock),
        .mode     (mode),
        .fix_pick (fix_pick),
        .rot_pick (rot_pick),
        .nxt      (state_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q.host_owns <= 1'b0;
            state_q.owner     <= RESET_OWNER;
        end else begin
            state_q <= state_d;
        end
    end

    assign host_grant = state_q.host_owns;
    assign owner_id   = state_q.host_owns ? '0 : state_q.owner;
    assign bus_master = !state_q.host_owns && (state_q.owner == my_id);

endmodule

// File: rtl/busarb_node_chk.sv
module busarb_node_chk
    import busarb_pkg::*;
#(
    parameter int NODES = 6
) (
    input logic             clk,
    input logic             rst,
    input logic [NODES-1:0] req_lines,
    input logic             host_req,
    input logic             lock,
    input logic             bus_master,
    input logic             host_grant,
    input logic [ID_W-1:0]  owner_id
);

    logic owner_req;

    always_comb begin
        owner_req = 1'b0;
        for (int i = 0; i < NODES; i++) begin
            if (owner_id == node_id_t'(i + 1)) begin
                owner_req = req_lines[i];
            end
        end
    end

    p_lock_hold_r8: assert property (@(posedge clk) disable iff (rst)
        lock |=> ($stable(owner_id) && $stable(host_grant)));

    p_tenure_r5: assert property (@(posedge clk) disable iff (rst)
        (!host_grant && owner_req) |=> $stable(owner_id));

    p_park_r9: assert property (@(posedge clk) disable iff (rst)
        (req_lines == '0 && !host_req && !host_grant) |=> $stable(owner_id));

    p_host_take_r6: assert property (@(posedge clk) disable iff (rst)
        (host_req && !lock && !host_grant && !owner_req) |=> (host_grant && owner_id == '0));

    p_host_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (host_grant && host_req) |=> host_grant);

    p_excl_r10: assert property (@(posedge clk) disable iff (rst)
        !(bus_master && host_grant));

    p_range_r11: assert property (@(posedge clk) disable iff (rst)
        (owner_id <= ID_W'(NODES)) && (host_grant == (owner_id == '0)));

endmodule

bind busarb_node busarb_node_chk #(.NODES(NODES)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_lines  (req_lines),
    .host_req   (host_req),
    .lock       (lock),
    .bus_master (bus_master),
    .host_grant (host_grant),
    .owner_id   (owner_id)
);

// File: tb/sim_busarb_node.sv
module sim_busarb_node;

    localparam int CLK_PERIOD = 10;
    localparam int N          = 6;
    localparam int WATCHDOG   = 20000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_rotate = 1'b0;
    logic [5:0] req_lines = '0;
    logic       host_req = 1'b0;
    logic       lock = 1'b0;

    logic       bm0, bm1, hg0, hg1;
    logic [2:0] oid0, oid1;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Reference state.
    int m_owner = 1;    // last or current processor owner
    bit m_host  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    busarb_node u0 (
        .clk(clk), .rst(rst), .cfg_rotate(cfg_rotate), .my_id(3'd3),
        .req_lines(req_lines), .host_req(host_req), .lock(lock),
        .bus_master(bm0), .host_grant(hg0), .owner_id(oid0)
    );

    busarb_node u1 (
        .clk(clk), .rst(rst), .cfg_rotate(cfg_rotate), .my_id(3'd5),
        .req_lines(req_lines), .host_req(host_req), .lock(lock),
        .bus_master(bm1), .host_grant(hg1), .owner_id(oid1)
    );

    function automatic int pick(input logic [5:0] r, input bit rot, input int last);
        if (!rot) begin
            for (int id = 1; id <= N; id++) if (r[id-1]) return id;
        end else begin
            for (int k = 1; k <= N; k++) begin
                int c;
                c = ((last - 1 + k) % N) + 1;
                if (r[c-1]) return c;
            end
        end
        return 0;
    endfunction

    task automatic model_step();
        int w;
        if (rst) begin
            m_owner = 1;
            m_host  = 0;
        end else if (!lock) begin
            w = pick(req_lines, cfg_rotate, m_owner);
            if (m_host) begin
                if (!host_req) begin
                    m_host = 0;
                    if (w != 0) m_owner = w;
                end
            end else if (!req_lines[m_owner-1]) begin
                if (host_req) m_host = 1;
                else if (w != 0) m_owner = w;
            end
        end
    endtask

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        int eo;
        eo = m_host ? 0 : m_owner;
        check(tag, "owner_id", int'(oid0), eo);
        check(tag, "owner_id node5", int'(oid1), eo);
        check(tag, "host_grant", int'(hg0), int'(m_host));
        check(tag, "bus_master node3", int'(bm0), int'(!m_host && m_owner == 3));
        check(tag, "bus_master node5", int'(bm1), int'(!m_host && m_owner == 5));
        check("R10", "exclusive masters", int'(bm0 && bm1), 0);
    endtask

    // Inputs are driven 1 time unit after an edge; the model advances at the
    // edge and outputs are compared 1 time unit later.
    task automatic tick(input string tag);
        @(posedge clk);
        model_step();
        #1;
        compare(tag);
    endtask

    task automatic drive(input logic [5:0] r, input bit h, input bit l);
        req_lines = r;
        host_req  = h;
        lock      = l;
    endtask

    initial begin
        int w;
        w = 0;
        while (!done && w < WATCHDOG) begin
            @(posedge clk);
            w++;
        end
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        rst = 1'b1;
        tick("R1");
        tick("R1");
        rst = 1'b0;
        check("R1", "owner after reset", int'(oid0), 1);
        check("R1", "host_grant after reset", int'(hg0), 0);

        // R9: parked with no requests
        drive(6'b000000, 0, 0);
        repeat (3) tick("R9");
        check("R9", "parked owner", int'(oid0), 1);

        // R3: fixed priority, IDs 3, 5 and 6 request; owner 1 not requesting
        drive(6'b110100, 0, 0);
        tick("R3");
        check("R3", "lowest ID wins", int'(oid0), 3);
        check("R10", "node3 master", int'(bm0), 1);

        // R5: owner 3 keeps the bus while ID 1 also requests
        drive(6'b110101, 0, 0);
        repeat (3) tick("R5");
        check("R5", "tenure", int'(oid0), 3);

        // R2: release by 3, new owner after exactly one edge
        drive(6'b110001, 0, 0);
        tick("R2");
        check("R2", "one-cycle changeover", int'(oid0), 1);

        // R11: only bit 4 requests -> ID 5
        drive(6'b010000, 0, 0);
        tick("R11");
        check("R11", "bit4 maps to ID5", int'(oid0), 5);
        check("R11", "node5 master", int'(bm1), 1);

        // R4: rotating from owner 5 with IDs 1, 2 and 6 requesting -> 6
        cfg_rotate = 1'b1;
        drive(6'b100011, 0, 0);
        tick("R4");
        check("R4", "next after 5", int'(oid0), 6);
        // wrap past 6: IDs 2 and 5 request -> 2
        drive(6'b010010, 0, 0);
        tick("R4");
        check("R4", "wrap to 2", int'(oid0), 2);
        // from 2: IDs 1 and 5 -> 5 (fixed mode would choose 1)
        drive(6'b010001, 0, 0);
        tick("R4");
        check("R4", "rotation skips ID 1", int'(oid0), 5);

        // R6: host waits while owner 5 requests, then takes the bus
        drive(6'b010001, 1, 0);
        repeat (2) tick("R6");
        check("R6", "host waits for release", int'(hg0), 0);
        drive(6'b000001, 1, 0);
        tick("R6");
        check("R6", "host granted", int'(hg0), 1);
        check("R6", "owner reads 0", int'(oid0), 0);
        check("R6", "no node master", int'(bm0 | bm1), 0);

        // R7: host holds, then hands back rotating from 5 -> 6
        drive(6'b111111, 1, 0);
        repeat (3) tick("R7");
        check("R7", "host holds", int'(hg0), 1);
        drive(6'b100001, 0, 0);
        tick("R7");
        check("R7", "rotation resumes after 5", int'(oid0), 6);
        drive(6'b000000, 1, 0);
        tick("R7");
        drive(6'b000000, 0, 0);
        tick("R7");
        check("R7", "return to last owner", int'(oid0), 6);

        // R8: lock holds owner 6 despite release, requests and host
        drive(6'b000101, 1, 1);
        repeat (4) tick("R8");
        check("R8", "locked owner", int'(oid0), 6);
        check("R8", "host ignored under lock", int'(hg0), 0);
        drive(6'b000101, 0, 0);
        tick("R8");
        check("R8", "arbitration after unlock", int'(oid0), 1);

        // Pseudo-random traffic, compared every cycle against the model
        for (int i = 0; i < 2000; i++) begin
            int r;
            r = $urandom_range(0, 99);
            drive(6'($urandom), ($urandom_range(0, 9) < 2), (r < 6));
            if (i % 250 == 0) cfg_rotate = ~cfg_rotate;
            tick("R2");
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule